// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller for a multicycle processor datapath. Each instruction is split into short steps: fetch, decode and operand read, execute, memory access and write-back. The controller advances through one step per clock and drives the enables and selects that the datapath needs for that step. A datapath register that is enabled in a state captures its new value on the clock edge that leaves that state.

The controller reads the 6-bit opcode held in the instruction register, the equality flag from the operand comparator, and two wait lines from the instruction and data memories. Fetch and the two data-memory states repeat while their memory reports wait. Capture enables that belong to those states are asserted only in the cycle that leaves them, so a slow memory stretches the instruction without any early capture.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-low reset puts the controller in the fetch step. The reset step has effect on the first rising edge while `rst_n` is low, including in the middle of an instruction.
- R2: In the fetch step `imem_rd` is 1. The step repeats while `imem_wait` is 1, and `ir_en` is 1 only in the cycle when `imem_wait` is 0, which is the last fetch cycle. The decode step follows.
- R3: The decode step lasts one cycle with `a_en` and `b_en` at 1. It dispatches on `opcode`: 000000 register-register, 001101 OR-immediate, 100011 load, 101011 store, 000100 branch-if-equal.
- R4: Register-register instructions take 4 cycles. The execute step has `alu_fn`=10 (function field), `alu_imm`=0 and `s_en`=1. The write-back step has `reg_wr`=1, `reg_dst`=1 (rd), `mem_to_reg`=0, `pc_en`=1 and `pc_sel`=0.
- R5: OR-immediate takes 4 cycles. The execute step has `ext_sign`=0 (zero extend), `alu_imm`=1, `alu_fn`=01 (OR) and `s_en`=1. The write-back step has `reg_wr`=1, `reg_dst`=0 (rt), `mem_to_reg`=0 and `pc_en`=1.
- R6: Load takes 5 cycles. The address step has `ext_sign`=1, `alu_imm`=1, `alu_fn`=00 (add) and `s_en`=1. The memory step has `dmem_rd`=1 and `m_en`=1 on its exit cycle. The write-back step has `reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0 and `pc_en`=1.
- R7: Store takes 4 cycles. The address step matches the load address step. The memory step has `dmem_wr`=1, with `pc_en`=1 and `pc_sel`=0 on its exit cycle.
- R8: Branch-if-equal takes 3 cycles. Its third step has `pc_en`=1, with `pc_sel`=1 (target) when `eq` was 1 at decode and `pc_sel`=0 (PC+4) when it was 0.
- R9: The load and store memory steps repeat while `dmem_wait` is 1. `dmem_rd` or `dmem_wr` stays 1 throughout, and `m_en` or `pc_en` is withheld until the exit cycle.
- R10: Any other opcode takes 3 cycles and ends in a PC+4 update. No `reg_wr`, `dmem_wr` or `dmem_rd` is asserted for it.
- R11: Every output that a step does not name is 0. `reg_wr` and `dmem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| eq | input | 1 | Operands compare equal |
| imem_wait | input | 1 | Instruction memory not ready |
| dmem_wait | input | 1 | Data memory not ready |
| imem_rd | output | 1 | Instruction memory read request |
| ir_en | output | 1 | Instruction register capture |
| pc_en | output | 1 | PC update |
| pc_sel | output | 1 | 1 = branch target, 0 = PC+4 |
| a_en | output | 1 | Operand A register capture |
| b_en | output | 1 | Operand B register capture |
| ext_sign | output | 1 | 1 = sign extend, 0 = zero extend immediate |
| alu_imm | output | 1 | ALU second operand is the immediate |
| alu_fn | output | 2 | 00 add, 01 OR, 10 use function field |
| s_en | output | 1 | ALU result register capture |
| dmem_rd | output | 1 | Data memory read request |
| m_en | output | 1 | Memory data register capture |
| dmem_wr | output | 1 | Data memory write strobe |
| mem_to_reg | output | 1 | Write-back data from memory register |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | 1 = rd, 0 = rt destination |

## Verification
All outputs decode the current step, and the step register is the only register in the path. A result therefore shows in the cycle after the edge that enters its step: decode outputs one cycle after a ready fetch, execute outputs two cycles after it, and so on, with each wait cycle adding one cycle. The bench works out these per-cycle output vectors from the opcode, the flag and the wait counts it applies, and queues one vector for every cycle it drives. The monitor pops one vector per cycle, a quarter period after the falling edge, so every comparison lands in exactly the cycle the requirements give and an extra or missing step shows up as a misalignment.

// File: rtl/mcc_pkg.sv
// Shared definitions for the multicycle control sequencer.
// Assumes a 4-bit step encoding and 6-bit opcodes.
package mcc_pkg;

    localparam int STATE_W = 4;
    localparam int OP_W    = 6;
    localparam int FN_W    = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BR_TAKE  = 4'b0010,
        ST_PC_INC   = 4'b0011,
        ST_RR_EXEC  = 4'b0100,
        ST_RR_WB    = 4'b0101,
        ST_ORI_EXEC = 4'b0110,
        ST_ORI_WB   = 4'b0111,
        ST_LD_ADDR  = 4'b1000,
        ST_LD_MEM   = 4'b1001,
        ST_LD_WB    = 4'b1010,
        ST_ST_ADDR  = 4'b1011,
        ST_ST_MEM   = 4'b1100
    } step_t;

    localparam logic [OP_W-1:0] OPC_RR  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BEQ = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ORI = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_ST  = 6'b101011;

    typedef enum logic [FN_W-1:0] {
        FN_ADD   = 2'b00,
        FN_OR    = 2'b01,
        FN_FUNCT = 2'b10
    } alu_fn_t;

    typedef struct packed {
        logic    imem_rd;
        logic    ir_en;
        logic    pc_en;
        logic    pc_sel;
        logic    a_en;
        logic    b_en;
        logic    ext_sign;
        logic    alu_imm;
        alu_fn_t alu_fn;
        logic    s_en;
        logic    dmem_rd;
        logic    m_en;
        logic    dmem_wr;
        logic    mem_to_reg;
        logic    reg_wr;
        logic    reg_dst;
    } ctrl_t;

endpackage

// File: rtl/mcc_step_reg.sv
// Step register of the sequencer.
// Synchronous active-low reset forces the fetch step.
module mcc_step_reg
    import mcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_t step_d,
    output step_t step_q
);

    // Capture the next step, or return to fetch under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_FETCH;
        end else begin
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/mcc_dispatch.sv
// Picks the first execution step from the opcode at decode.
// Assumes the opcode and eq flag are valid during decode. Unknown
// opcodes map to the PC+4 step, so nothing is written for them.
module mcc_dispatch
    import mcc_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] opcode,
    input  logic           eq,
    output step_t          target
);

    // Map each supported opcode to its execute-class entry step.
    always_comb begin
        case (opcode)
            OPC_RR:  target = ST_RR_EXEC;
            OPC_ORI: target = ST_ORI_EXEC;
            OPC_LD:  target = ST_LD_ADDR;
            OPC_ST:  target = ST_ST_ADDR;
            OPC_BEQ: target = eq ? ST_BR_TAKE : ST_PC_INC;
            default: target = ST_PC_INC;
        endcase
    end

endmodule

// File: rtl/mcc_next_step.sv
// Next-step logic: fixed successors, the decode dispatch and
// self-loops on the fetch and data-memory steps while memory waits.
// Assumes unused encodings should fall back to fetch.
module mcc_next_step
    import mcc_pkg::*;
(
    input  step_t step_q,
    input  step_t dispatch,
    input  logic  imem_wait,
    input  logic  dmem_wait,
    output step_t step_d
);

    // Choose the successor of the current step.
    always_comb begin
        case (step_q)
            ST_FETCH:    step_d = imem_wait ? ST_FETCH : ST_DECODE;
            ST_DECODE:   step_d = dispatch;
            ST_RR_EXEC:  step_d = ST_RR_WB;
            ST_ORI_EXEC: step_d = ST_ORI_WB;
            ST_LD_ADDR:  step_d = ST_LD_MEM;
            ST_LD_MEM:   step_d = dmem_wait ? ST_LD_MEM : ST_LD_WB;
            ST_ST_ADDR:  step_d = ST_ST_MEM;
            ST_ST_MEM:   step_d = dmem_wait ? ST_ST_MEM : ST_FETCH;
            default:     step_d = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
// Decodes the current step into datapath controls.
// Capture enables of waiting steps are raised only in the exit cycle.
// Outputs a step does not use are driven to 0.
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  step_t step_q,
    input  logic  imem_wait,
    input  logic  dmem_wait,
    output ctrl_t ctrl
);

    // Build the control word for the current step.
    always_comb begin
        ctrl = '0;
        case (step_q)
            ST_FETCH: begin
                ctrl.imem_rd = 1'b1;
                ctrl.ir_en   = !imem_wait;
            end
            ST_DECODE: begin
                ctrl.a_en = 1'b1;
                ctrl.b_en = 1'b1;
            end
            ST_BR_TAKE: begin
                ctrl.pc_en  = 1'b1;
                ctrl.pc_sel = 1'b1;
            end
            ST_PC_INC: begin
                ctrl.pc_en = 1'b1;
            end
            ST_RR_EXEC: begin
                ctrl.alu_fn = FN_FUNCT;
                ctrl.s_en   = 1'b1;
            end
            ST_RR_WB: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.reg_dst = 1'b1;
                ctrl.pc_en   = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctrl.alu_imm = 1'b1;
                ctrl.alu_fn  = FN_OR;
                ctrl.s_en    = 1'b1;
            end
            ST_ORI_WB: begin
                ctrl.reg_wr = 1'b1;
                ctrl.pc_en  = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctrl.ext_sign = 1'b1;
                ctrl.alu_imm  = 1'b1;
                ctrl.alu_fn   = FN_ADD;
                ctrl.s_en     = 1'b1;
            end
            ST_LD_MEM: begin
                ctrl.dmem_rd = 1'b1;
                ctrl.m_en    = !dmem_wait;
            end
            ST_LD_WB: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.pc_en      = 1'b1;
            end
            ST_ST_MEM: begin
                ctrl.dmem_wr = 1'b1;
                ctrl.pc_en   = !dmem_wait;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Hardwired controller for a multicycle datapath. It links the step
// register, dispatch, next-step logic and control decode. Assumes
// opcode and eq are stable from decode to the end of the instruction.
module mc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            eq,
    input  logic            imem_wait,
    input  logic            dmem_wait,
    output logic            imem_rd,
    output logic            ir_en,
    output logic            pc_en,
    output logic            pc_sel,
    output logic            a_en,
    output logic            b_en,
    output logic            ext_sign,
    output logic            alu_imm,
    output logic [FN_W-1:0] alu_fn,
    output logic            s_en,
    output logic            dmem_rd,
    output logic            m_en,
    output logic            dmem_wr,
    output logic            mem_to_reg,
    output logic            reg_wr,
    output logic            reg_dst
);

    step_t step_q;
    step_t step_d;
    step_t dispatch;
    ctrl_t ctrl;

    mcc_step_reg u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_d (step_d),
        .step_q (step_q)
    );

    mcc_dispatch #(.OPW(OP_W)) u_disp (
        .opcode (opcode),
        .eq     (eq),
        .target (dispatch)
    );

    mcc_next_step u_next (
        .step_q    (step_q),
        .dispatch  (dispatch),
        .imem_wait (imem_wait),
        .dmem_wait (dmem_wait),
        .step_d    (step_d)
    );

    mcc_ctrl_decode u_dec (
        .step_q    (step_q),
        .imem_wait (imem_wait),
        .dmem_wait (dmem_wait),
        .ctrl      (ctrl)
    );

    // Unpack the control word onto the ports.
    always_comb begin
        imem_rd    = ctrl.imem_rd;
        ir_en      = ctrl.ir_en;
        pc_en      = ctrl.pc_en;
        pc_sel     = ctrl.pc_sel;
        a_en       = ctrl.a_en;
        b_en       = ctrl.b_en;
        ext_sign   = ctrl.ext_sign;
        alu_imm    = ctrl.alu_imm;
        alu_fn     = ctrl.alu_fn;
        s_en       = ctrl.s_en;
        dmem_rd    = ctrl.dmem_rd;
        m_en       = ctrl.m_en;
        dmem_wr    = ctrl.dmem_wr;
        mem_to_reg = ctrl.mem_to_reg;
        reg_wr     = ctrl.reg_wr;
        reg_dst    = ctrl.reg_dst;
    end

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
// Temporal checks on the sequencer, bound to every instance of it.
// Assumes the step register is visible as step_q in the bound scope.
module mc_ctrl_fsm_chk
    import mcc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    opcode,
    input logic               imem_wait,
    input logic               dmem_wait,
    input logic [STATE_W-1:0] step_q,
    input logic               imem_rd,
    input logic               ir_en,
    input logic               pc_en,
    input logic               pc_sel,
    input logic               a_en,
    input logic               dmem_rd,
    input logic               dmem_wr,
    input logic               reg_wr
);

    // R1
    rst_to_fetch_chk: assert property (@(posedge clk)
        !rst_n |=> step_q == ST_FETCH);

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rd && imem_wait) |=> imem_rd);

    // R3
    decode_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_en |=> a_en);

    // R9
    ld_mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd && dmem_wait) |=> dmem_rd);

    // R9
    st_mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_wr && dmem_wait) |=> dmem_wr);

    // R10
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && opcode != OPC_RR && opcode != OPC_ORI && opcode != OPC_LD
         && opcode != OPC_ST && opcode != OPC_BEQ)
        |=> (pc_en && !pc_sel && !reg_wr && !dmem_wr && !dmem_rd));

    // R11
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, dmem_wr}));

    // R11
    pc_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |=> imem_rd);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .imem_wait (imem_wait),
    .dmem_wait (dmem_wait),
    .step_q    (step_q),
    .imem_rd   (imem_rd),
    .ir_en     (ir_en),
    .pc_en     (pc_en),
    .pc_sel    (pc_sel),
    .a_en      (a_en),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .reg_wr    (reg_wr)
);

// File: tb/mc_ctrl_fsm_tb_top.sv
// Scoreboard bench: the driver queues one expected control vector per
// driven cycle; the monitor pops and compares one per cycle.
module mc_ctrl_fsm_tb_top;

    localparam int CYC_NS   = 20;
    localparam int WATCHDOG = 100000;

    typedef enum int {
        PH_FETCH, PH_DEC, PH_BRT, PH_INC, PH_REX, PH_RWB,
        PH_OEX, PH_OWB, PH_ADDR, PH_LMEM, PH_LWB, PH_SMEM
    } ph_t;

    typedef struct {
        logic [16:0] vec;
        string       tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic       eq = 1'b0;
    logic       imem_wait = 1'b0;
    logic       dmem_wait = 1'b0;
    logic       imem_rd, ir_en, pc_en, pc_sel, a_en, b_en, ext_sign, alu_imm;
    logic [1:0] alu_fn;
    logic       s_en, dmem_rd, m_en, dmem_wr, mem_to_reg, reg_wr, reg_dst;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #(CYC_NS/2) clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .eq(eq),
        .imem_wait(imem_wait), .dmem_wait(dmem_wait),
        .imem_rd(imem_rd), .ir_en(ir_en), .pc_en(pc_en), .pc_sel(pc_sel),
        .a_en(a_en), .b_en(b_en), .ext_sign(ext_sign), .alu_imm(alu_imm),
        .alu_fn(alu_fn), .s_en(s_en), .dmem_rd(dmem_rd), .m_en(m_en),
        .dmem_wr(dmem_wr), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
        .reg_dst(reg_dst)
    );

    // Order: imem_rd ir_en pc_en pc_sel a_en b_en ext_sign alu_imm
    //        alu_fn[1:0] s_en dmem_rd m_en dmem_wr mem_to_reg reg_wr reg_dst
    function automatic logic [16:0] pack(
        bit ird, bit ire, bit pce, bit pcs, bit ae, bit be, bit ext, bit imm,
        bit [1:0] fn, bit se, bit drd, bit me, bit dwr, bit m2r, bit rw, bit rd);
        return {ird, ire, pce, pcs, ae, be, ext, imm, fn, se, drd, me, dwr, m2r, rw, rd};
    endfunction

    function automatic logic [16:0] exp_vec(ph_t ph, bit w);
        case (ph)
            PH_FETCH: return pack(1, !w, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
            PH_DEC:   return pack(0, 0, 0, 0, 1, 1, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
            PH_BRT:   return pack(0, 0, 1, 1, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
            PH_INC:   return pack(0, 0, 1, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
            PH_REX:   return pack(0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 1, 0, 0, 0, 0, 0, 0);
            PH_RWB:   return pack(0, 0, 1, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 1);
            PH_OEX:   return pack(0, 0, 0, 0, 0, 0, 0, 1, 2'b01, 1, 0, 0, 0, 0, 0, 0);
            PH_OWB:   return pack(0, 0, 1, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0);
            PH_ADDR:  return pack(0, 0, 0, 0, 0, 0, 1, 1, 2'b00, 1, 0, 0, 0, 0, 0, 0);
            PH_LMEM:  return pack(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 1, !w, 0, 0, 0, 0);
            PH_LWB:   return pack(0, 0, 1, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 1, 1, 0);
            PH_SMEM:  return pack(0, 0, !w, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1, 0, 0, 0);
            default:  return '0;
        endcase
    endfunction

    // Drive one cycle and queue its expected output vector.
    task automatic step(ph_t ph, bit iw, bit dw, string tag);
        item_t it;
        imem_wait = iw;
        dmem_wait = dw;
        it.vec = exp_vec(ph, (ph == PH_FETCH) ? iw : dw);
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    // Drive a whole instruction with the given wait-cycle counts.
    task automatic run(logic [5:0] op, bit f, int iwn, int dwn, string tag);
        opcode = op;
        eq = f;
        for (int i = 0; i < iwn; i++) step(PH_FETCH, 1, 0, "R2");
        step(PH_FETCH, 0, 1, "R2");
        step(PH_DEC, 1, 0, "R3");
        case (op)
            6'b000000: begin step(PH_REX, 1, 1, tag); step(PH_RWB, 0, 0, tag); end
            6'b001101: begin step(PH_OEX, 0, 0, tag); step(PH_OWB, 0, 0, tag); end
            6'b100011: begin
                step(PH_ADDR, 0, 0, tag);
                for (int i = 0; i < dwn; i++) step(PH_LMEM, 1, 1, "R9");
                step(PH_LMEM, 1, 0, tag);
                step(PH_LWB, 0, 1, tag);
            end
            6'b101011: begin
                step(PH_ADDR, 0, 0, tag);
                for (int i = 0; i < dwn; i++) step(PH_SMEM, 0, 1, "R9");
                step(PH_SMEM, 0, 0, tag);
            end
            6'b000100: step(f ? PH_BRT : PH_INC, 0, 0, tag);
            default:   step(PH_INC, 0, 0, tag);
        endcase
    endtask

    // Monitor: compare one queued vector per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CYC_NS/4);
            if (q.size() > 0) begin
                item_t it;
                logic [16:0] act;
                it = q.pop_front();
                act = {imem_rd, ir_en, pc_en, pc_sel, a_en, b_en, ext_sign, alu_imm,
                       alu_fn, s_en, dmem_rd, m_en, dmem_wr, mem_to_reg, reg_wr, reg_dst};
                n_chk++;
                if (act !== it.vec) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b at %0t", it.tag, act, it.vec, $time);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        step(PH_FETCH, 0, 0, "R1");         // reset held: fetch outputs
        rst_n = 1'b1;
        run(6'b000000, 0, 0, 0, "R4");
        run(6'b001101, 0, 0, 0, "R5");
        run(6'b100011, 0, 0, 0, "R6");
        run(6'b101011, 1, 0, 0, "R7");
        run(6'b000100, 1, 0, 0, "R8");
        run(6'b000100, 0, 0, 0, "R8");
        run(6'b111111, 1, 0, 0, "R10");
        run(6'b000010, 0, 0, 0, "R10");
        run(6'b100011, 0, 2, 3, "R9");
        run(6'b101011, 0, 1, 2, "R9");
        run(6'b000000, 1, 3, 0, "R2");
        // R1: reset in the middle of a load returns to fetch
        opcode = 6'b100011;
        step(PH_FETCH, 0, 0, "R1");
        step(PH_DEC, 0, 0, "R1");
        rst_n = 1'b0;
        step(PH_ADDR, 0, 0, "R1");
        rst_n = 1'b1;
        step(PH_FETCH, 0, 0, "R1");
        step(PH_DEC, 0, 0, "R1");
        step(PH_ADDR, 0, 0, "R11");
        step(PH_LMEM, 0, 0, "R11");
        step(PH_LWB, 0, 0, "R11");
        run(6'b001101, 0, 0, 0, "R11");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule